// File: doc/BRIEF.md
# Sectored Directory Entry Controller

This block holds the coherence directory for the blocks of a shared L2 cache in a chip multiprocessor with `P` cores, each core having a private L1. Every L2 block is `K` L1 sectors wide. The block keeps one directory entry per L2 block, next to the tag, and reads it on the same lookup that serves a forwarded L1 request. The hierarchy is inclusive, so no separate directory store is needed. Each request is a read miss, a write miss or upgrade, or a dirty-sector writeback from one core to one sector. For each request the block updates the entry and reports the coherence action it needs: plain data supply, an intervention to the owning L1, invalidations to sharers, a writeback acknowledge, or an error.

An entry is in one of three states: invalid, shared, or L1-modified. In the shared state the `P`-bit field is a sharer vector. In the L1-modified state the same `P` bits hold the owner's core number. They also hold the number of that owner's dirty sectors, stored minus one. Because of this count, the modified state ends when the last dirty sector comes home, and later misses from other cores no longer trigger interventions. Elaboration rejects any `P`, `K` pair for which owner and count do not fit in `P` bits.

Top module: `sector_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, and every entry is invalid (state 0, field 0, dirty mask 0).
- R2: An accepted request (`req_valid` and `req_ready`) gives `rsp_valid` high on the next cycle. A cycle with no accepted request gives `rsp_valid` low on the next cycle. A request sees every update made by the requests accepted before it, including the one in the cycle just before.
- R3: A read (op 0) to an invalid or shared entry answers SUPPLY (action 1) with zero targets. The entry is left in shared state (1) with the requester's bit set in the sharer vector.
- R4: A read from a non-owner to a modified entry (state 2) answers INTERVENE (action 2) with the owner's one-hot bit as target. The entry becomes shared with exactly the owner and requester bits set, and its dirty mask is cleared. A read from the owner answers SUPPLY and leaves the entry unchanged.
- R5: A write (op 1) to a shared entry answers INVALIDATE (action 3) with the sharer vector minus the requester as targets. If no other sharer exists, it answers SUPPLY instead. The entry becomes modified with the requester as owner and a dirty count of one.
- R6: In modified state, field bits [log2 P-1:0] hold the owner, the next log2 K bits hold the dirty count minus one, and all higher bits are zero. The dirty mask (bit i = sector i) has exactly as many ones as the count.
- R7: A write from the owner to a clean sector answers SUPPLY, sets that sector's mask bit and raises the count by one. A write from the owner to a sector that is already dirty changes nothing.
- R8: A write from another core to a modified entry answers INTERVENE to the old owner. Ownership moves to the writer, the count becomes one, and the mask holds only the written sector. A write to an invalid entry answers SUPPLY and gives the same one-sector modified entry.
- R9: A writeback (op 2) from the owner of a dirty sector answers WB_ACK (action 4), clears that mask bit and lowers the count. When the last dirty sector is written back, the entry becomes shared with only the owner's bit set.
- R10: A writeback of a clean sector, a writeback from a non-owner, a writeback to a non-modified entry, and the reserved op 3 all answer ERROR (action 5) with zero targets, and leave the entry unchanged.
- R11: A request changes only the entry selected by `req_blk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 read, 1 write, 2 writeback, 3 reserved |
| req_core | input | log2 P | Requesting core |
| req_blk | input | log2 NB | L2 block (entry) index |
| req_sector | input | log2 K | Sector within the block |
| rsp_valid | output | 1 | Response present |
| rsp_action | output | 3 | 1 SUPPLY, 2 INTERVENE, 3 INVALIDATE, 4 WB_ACK, 5 ERROR |
| rsp_targets | output | P | One-hot or vector of cores that receive the action |
| rsp_state | output | 2 | Entry state after update: 0 invalid, 1 shared, 2 modified |
| rsp_field | output | P | Packed sharer vector or owner/count after update |
| rsp_dirty | output | K | Dirty-sector mask after update |

## Verification
The entry is driven through several patterns. Read sharing by two cores shows that sharer bits accumulate. A write into a shared block with other sharers, and one where the writer is the only sharer, tells INVALIDATE apart from SUPPLY. Owner writes to fresh and to already-dirty sectors show whether the count is raised once per sector. A foreign write and a foreign read to a modified block separate ownership transfer from a fall back to shared. Writebacks cover the legal partial and final cases and three illegal ones, which shows whether the modified state ends exactly at the last dirty sector. Back-to-back requests to one block, and checks on blocks that were never touched, show that each update reaches the next request and stays inside its own entry.

// File: rtl/sdir_pkg.sv
package sdir_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_MOD = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_WB  = 2'd2,
    OP_RSV = 2'd3
  } dop_e;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_SUPPLY = 3'd1,
    ACT_INTV   = 3'd2,
    ACT_INVAL  = 3'd3,
    ACT_WBACK  = 3'd4,
    ACT_ERR    = 3'd5
  } daction_e;

endpackage

// File: rtl/sdir_field_codec.sv
// Overlays owner id and (dirty count - 1) on the low bits of the sharer field.
module sdir_field_codec #(
  parameter int P = 8,
  parameter int K = 4,
  localparam int LOGP = $clog2(P),
  localparam int LOGK = $clog2(K)
) (
  input  logic [P-1:0]    in_field,
  output logic [LOGP-1:0] out_owner,
  output logic [LOGK-1:0] out_cnt_m1,
  input  logic [LOGP-1:0] in_owner,
  input  logic [LOGK-1:0] in_cnt_m1,
  output logic [P-1:0]    out_field
);

  generate
    if (P < LOGP + LOGK) begin : g_fit_bad
      $error("owner and count do not fit in the sharer field");
    end
  endgenerate

  assign out_owner  = in_field[LOGP-1:0];
  assign out_cnt_m1 = in_field[LOGP +: LOGK];

  always_comb begin
    out_field                = '0;
    out_field[LOGP-1:0]      = in_owner;
    out_field[LOGP +: LOGK]  = in_cnt_m1;
  end

endmodule

// File: rtl/sdir_next.sv
// Combinational transition of one directory entry for one request.
module sdir_next
  import sdir_pkg::*;
#(
  parameter int P = 8,
  parameter int K = 4,
  localparam int LOGP = $clog2(P),
  localparam int LOGK = $clog2(K)
) (
  input  logic [1:0]      op,
  input  logic [LOGP-1:0] core,
  input  logic [LOGK-1:0] sector,
  input  logic [1:0]      cur_state,
  input  logic [P-1:0]    cur_field,
  input  logic [K-1:0]    cur_dirty,
  output logic            upd,
  output logic [1:0]      nxt_state,
  output logic [P-1:0]    nxt_field,
  output logic [K-1:0]    nxt_dirty,
  output logic [2:0]      action,
  output logic [P-1:0]    targets
);

  logic [LOGP-1:0] cur_owner;
  logic [LOGK-1:0] cur_cnt;
  logic [LOGK-1:0] enc_cnt;
  logic [P-1:0]    enc_field;
  logic [P-1:0]    req_bit;
  logic [P-1:0]    own_bit;
  logic [K-1:0]    sec_bit;
  logic            own_match;
  logic            is_mod;
  logic [P-1:0]    other_sharers;

  sdir_field_codec #(.P(P), .K(K)) u_codec (
    .in_field   (cur_field),
    .out_owner  (cur_owner),
    .out_cnt_m1 (cur_cnt),
    .in_owner   (core),
    .in_cnt_m1  (enc_cnt),
    .out_field  (enc_field)
  );

  assign is_mod        = (cur_state == ST_MOD);
  assign own_match     = (cur_owner == core);
  assign other_sharers = cur_field & ~req_bit;

  always_comb begin
    req_bit          = '0;
    req_bit[core]    = 1'b1;
    own_bit          = '0;
    own_bit[cur_owner] = 1'b1;
    sec_bit          = '0;
    sec_bit[sector]  = 1'b1;
  end

  // count to encode: +1 on owner write to clean sector, -1 on writeback, else 1
  always_comb begin
    if (op == OP_WR && is_mod && own_match) begin
      enc_cnt = cur_cnt + 1'b1;
    end else if (op == OP_WB) begin
      enc_cnt = cur_cnt - 1'b1;
    end else begin
      enc_cnt = '0;
    end
  end

  always_comb begin
    upd       = 1'b0;
    nxt_state = cur_state;
    nxt_field = cur_field;
    nxt_dirty = cur_dirty;
    action    = ACT_ERR;
    targets   = '0;
    case (op)
      OP_RD: begin
        case (cur_state)
          ST_INV: begin
            upd = 1'b1; nxt_state = ST_SHR; nxt_field = req_bit;
            nxt_dirty = '0; action = ACT_SUPPLY;
          end
          ST_SHR: begin
            upd = 1'b1; nxt_field = cur_field | req_bit; action = ACT_SUPPLY;
          end
          ST_MOD: begin
            if (own_match) begin
              action = ACT_SUPPLY;
            end else begin
              upd = 1'b1; nxt_state = ST_SHR; nxt_field = own_bit | req_bit;
              nxt_dirty = '0; action = ACT_INTV; targets = own_bit;
            end
          end
          default: action = ACT_ERR;
        endcase
      end
      OP_WR: begin
        case (cur_state)
          ST_INV: begin
            upd = 1'b1; nxt_state = ST_MOD; nxt_field = enc_field;
            nxt_dirty = sec_bit; action = ACT_SUPPLY;
          end
          ST_SHR: begin
            upd = 1'b1; nxt_state = ST_MOD; nxt_field = enc_field;
            nxt_dirty = sec_bit; targets = other_sharers;
            action = (other_sharers != '0) ? ACT_INVAL : ACT_SUPPLY;
          end
          ST_MOD: begin
            if (own_match) begin
              action = ACT_SUPPLY;
              if (!cur_dirty[sector]) begin
                upd = 1'b1; nxt_field = enc_field; nxt_dirty = cur_dirty | sec_bit;
              end
            end else begin
              upd = 1'b1; nxt_field = enc_field; nxt_dirty = sec_bit;
              action = ACT_INTV; targets = own_bit;
            end
          end
          default: action = ACT_ERR;
        endcase
      end
      OP_WB: begin
        if (is_mod && own_match && cur_dirty[sector]) begin
          upd = 1'b1; action = ACT_WBACK; nxt_dirty = cur_dirty & ~sec_bit;
          if (cur_cnt == '0) begin
            nxt_state = ST_SHR; nxt_field = req_bit;
          end else begin
            nxt_field = enc_field;
          end
        end
      end
      default: action = ACT_ERR;
    endcase
  end

endmodule

// File: rtl/sdir_store.sv
// Register array of directory entries, one per L2 block.
module sdir_store
  import sdir_pkg::*;
#(
  parameter int P  = 8,
  parameter int K  = 4,
  parameter int NB = 8,
  localparam int LOGB = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LOGB-1:0] rd_idx,
  output logic [1:0]      rd_state,
  output logic [P-1:0]    rd_field,
  output logic [K-1:0]    rd_dirty,
  input  logic            wr_en,
  input  logic [LOGB-1:0] wr_idx,
  input  logic [1:0]      wr_state,
  input  logic [P-1:0]    wr_field,
  input  logic [K-1:0]    wr_dirty
);

  logic [1:0]   st_q  [NB];
  logic [P-1:0] fld_q [NB];
  logic [K-1:0] dty_q [NB];

  generate
    for (genvar g = 0; g < NB; g++) begin : g_ent
      logic ent_en;
      assign ent_en = wr_en && (wr_idx == LOGB'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g]  <= ST_INV;
          fld_q[g] <= '0;
          dty_q[g] <= '0;
        end else if (ent_en) begin
          st_q[g]  <= wr_state;
          fld_q[g] <= wr_field;
          dty_q[g] <= wr_dirty;
        end
      end
    end
  endgenerate

  assign rd_state = st_q[rd_idx];
  assign rd_field = fld_q[rd_idx];
  assign rd_dirty = dty_q[rd_idx];

endmodule

// File: rtl/sector_dir_ctrl.sv
module sector_dir_ctrl
  import sdir_pkg::*;
#(
  parameter int P  = 8,
  parameter int K  = 4,
  parameter int NB = 8,
  localparam int LOGP = $clog2(P),
  localparam int LOGK = $clog2(K),
  localparam int LOGB = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [LOGP-1:0] req_core,
  input  logic [LOGB-1:0] req_blk,
  input  logic [LOGK-1:0] req_sector,
  output logic            rsp_valid,
  output logic [2:0]      rsp_action,
  output logic [P-1:0]    rsp_targets,
  output logic [1:0]      rsp_state,
  output logic [P-1:0]    rsp_field,
  output logic [K-1:0]    rsp_dirty
);

  generate
    if (P < LOGP + LOGK) begin : g_pack_bad
      $error("P too small to hold owner and dirty count");
    end
    if (K < 2 || (1 << LOGK) != K || P < 2 || (1 << LOGP) != P) begin : g_pow_bad
      $error("P and K must be powers of two, at least 2");
    end
  endgenerate

  logic         accept;
  logic [1:0]   cur_state;
  logic [P-1:0] cur_field;
  logic [K-1:0] cur_dirty;
  logic         upd;
  logic [1:0]   nxt_state;
  logic [P-1:0] nxt_field;
  logic [K-1:0] nxt_dirty;
  logic [2:0]   nxt_action;
  logic [P-1:0] nxt_targets;

  logic         ready_q;
  logic         vld_q;
  logic [2:0]   act_q;
  logic [P-1:0] tgt_q;
  logic [1:0]   st_q;
  logic [P-1:0] fld_q;
  logic [K-1:0] dty_q;

  assign accept = req_valid && ready_q;

  sdir_store #(.P(P), .K(K), .NB(NB)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_blk),
    .rd_state (cur_state),
    .rd_field (cur_field),
    .rd_dirty (cur_dirty),
    .wr_en    (accept && upd),
    .wr_idx   (req_blk),
    .wr_state (nxt_state),
    .wr_field (nxt_field),
    .wr_dirty (nxt_dirty)
  );

  sdir_next #(.P(P), .K(K)) u_next (
    .op        (req_op),
    .core      (req_core),
    .sector    (req_sector),
    .cur_state (cur_state),
    .cur_field (cur_field),
    .cur_dirty (cur_dirty),
    .upd       (upd),
    .nxt_state (nxt_state),
    .nxt_field (nxt_field),
    .nxt_dirty (nxt_dirty),
    .action    (nxt_action),
    .targets   (nxt_targets)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= ACT_NONE;
      tgt_q <= '0;
      st_q  <= ST_INV;
      fld_q <= '0;
      dty_q <= '0;
    end else if (accept) begin
      act_q <= nxt_action;
      tgt_q <= nxt_targets;
      st_q  <= nxt_state;
      fld_q <= nxt_field;
      dty_q <= nxt_dirty;
    end
  end

  assign req_ready   = ready_q;
  assign rsp_valid   = vld_q;
  assign rsp_action  = act_q;
  assign rsp_targets = tgt_q;
  assign rsp_state   = st_q;
  assign rsp_field   = fld_q;
  assign rsp_dirty   = dty_q;

endmodule

// File: rtl/sector_dir_ctrl_chk.sv
module sector_dir_ctrl_chk #(
  parameter int P  = 8,
  parameter int K  = 4,
  parameter int NB = 8,
  localparam int LOGP = $clog2(P),
  localparam int LOGK = $clog2(K)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         rsp_valid,
  input logic [2:0]   rsp_action,
  input logic [P-1:0] rsp_targets,
  input logic [1:0]   rsp_state,
  input logic [P-1:0] rsp_field,
  input logic [K-1:0] rsp_dirty
);

  logic [LOGP-1:0] f_owner;
  logic [LOGK:0]   f_cnt;
  logic            f_high_zero;

  assign f_owner = rsp_field[LOGP-1:0];
  assign f_cnt   = {1'b0, rsp_field[LOGP +: LOGK]} + 1'b1;
  assign f_high_zero = ((rsp_field >> (LOGP + LOGK)) == '0);

  // R2
  resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R4
  intervene_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_action == 3'd2) |-> ($countones(rsp_targets) == 1));

  // R5
  inval_excludes_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_action == 3'd3) |->
      (rsp_state == 2'd2 && rsp_targets != '0 && !rsp_targets[f_owner]));

  // R6
  packed_count_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state == 2'd2) |->
      (f_high_zero && $countones(rsp_dirty) == int'(f_cnt)));

  // R9
  shared_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state == 2'd1) |-> (rsp_dirty == '0 && rsp_field != '0));

  // R10
  error_no_targets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_action == 3'd5) |-> (rsp_targets == '0));

  // R1
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_state != 2'd3));

endmodule

bind sector_dir_ctrl sector_dir_ctrl_chk #(.P(P), .K(K), .NB(NB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_action  (rsp_action),
  .rsp_targets (rsp_targets),
  .rsp_state   (rsp_state),
  .rsp_field   (rsp_field),
  .rsp_dirty   (rsp_dirty)
);

// File: tb/sector_dir_ctrl_tb.sv
module sector_dir_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P  = 8;
  localparam int K  = 4;
  localparam int NB = 8;

  localparam logic [2:0] A_SUP = 3'd1, A_INT = 3'd2, A_INV = 3'd3,
                         A_WBA = 3'd4, A_ERR = 3'd5;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_M = 2'd2;
  localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_WB = 2'd2, O_RS = 2'd3;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_op;
  logic [2:0] req_core;
  logic [2:0] req_blk;
  logic [1:0] req_sector;
  logic       rsp_valid;
  logic [2:0] rsp_action;
  logic [7:0] rsp_targets;
  logic [1:0] rsp_state;
  logic [7:0] rsp_field;
  logic [3:0] rsp_dirty;

  int n_tests = 0;
  int n_fail  = 0;

  sector_dir_ctrl #(.P(P), .K(K), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_core(req_core), .req_blk(req_blk), .req_sector(req_sector),
    .rsp_valid(rsp_valid), .rsp_action(rsp_action), .rsp_targets(rsp_targets),
    .rsp_state(rsp_state), .rsp_field(rsp_field), .rsp_dirty(rsp_dirty)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // modified-state field: owner in [2:0], count-1 in [4:3]
  function automatic logic [7:0] mfld(input int owner, input int cnt);
    return 8'(owner) | 8'((cnt - 1) << 3);
  endfunction

  task automatic set_req(input logic [1:0] op, input int core, input int blk, input int sec);
    req_valid  = 1'b1;
    req_op     = op;
    req_core   = 3'(core);
    req_blk    = 3'(blk);
    req_sector = 2'(sec);
  endtask

  task automatic expect_rsp(input string tag, input logic [2:0] act, input logic [7:0] tgt,
                            input logic [1:0] st, input logic [7:0] fld, input logic [3:0] dty);
    n_tests++;
    if (rsp_valid !== 1'b1 || rsp_action !== act || rsp_targets !== tgt ||
        rsp_state !== st || rsp_field !== fld || rsp_dirty !== dty) begin
      n_fail++;
      $display("FAIL %s: got v=%b act=%0d tgt=%h st=%0d fld=%h dty=%b, expected v=1 act=%0d tgt=%h st=%0d fld=%h dty=%b",
               tag, rsp_valid, rsp_action, rsp_targets, rsp_state, rsp_field, rsp_dirty,
               act, tgt, st, fld, dty);
    end
  endtask

  // one request; outputs sampled on the negedge after the capturing posedge
  task automatic req1(input string tag, input logic [1:0] op, input int core, input int blk,
                      input int sec, input logic [2:0] act, input logic [7:0] tgt,
                      input logic [1:0] st, input logic [7:0] fld, input logic [3:0] dty);
    @(negedge clk);
    set_req(op, core, blk, sec);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, act, tgt, st, fld, dty);
  endtask

  task automatic t_reset;
    n_tests++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: ready=%b rsp_valid=%b, expected 1 and 0", req_ready, rsp_valid);
    end
    // an untouched entry is invalid: writeback errors and shows state I
    req1("R1 fresh entry", O_WB, 0, 7, 0, A_ERR, 8'h00, S_I, 8'h00, 4'b0000);
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: idle cycle rsp_valid=%b, expected 0", rsp_valid);
    end
  endtask

  task automatic t_read_share;
    req1("R3 read invalid", O_RD, 2, 0, 0, A_SUP, 8'h00, S_S, 8'h04, 4'b0000);
    req1("R3 read shared",  O_RD, 5, 0, 2, A_SUP, 8'h00, S_S, 8'h24, 4'b0000);
  endtask

  task automatic t_write_shared;
    req1("R5 R6 write shared", O_WR, 5, 0, 1, A_INV, 8'h04, S_M, mfld(5, 1), 4'b0010);
  endtask

  task automatic t_owner_writes;
    req1("R7 owner new sector", O_WR, 5, 0, 3, A_SUP, 8'h00, S_M, mfld(5, 2), 4'b1010);
    req1("R7 owner same sector", O_WR, 5, 0, 3, A_SUP, 8'h00, S_M, mfld(5, 2), 4'b1010);
  endtask

  task automatic t_writebacks;
    req1("R9 wb partial", O_WB, 5, 0, 1, A_WBA, 8'h00, S_M, mfld(5, 1), 4'b1000);
    req1("R10 wb clean sector", O_WB, 5, 0, 1, A_ERR, 8'h00, S_M, mfld(5, 1), 4'b1000);
    req1("R10 wb non-owner", O_WB, 2, 0, 3, A_ERR, 8'h00, S_M, mfld(5, 1), 4'b1000);
    req1("R9 wb last", O_WB, 5, 0, 3, A_WBA, 8'h00, S_S, 8'h20, 4'b0000);
    req1("R10 wb shared entry", O_WB, 5, 0, 3, A_ERR, 8'h00, S_S, 8'h20, 4'b0000);
  endtask

  task automatic t_ownership_move;
    req1("R8 write invalid", O_WR, 1, 1, 0, A_SUP, 8'h00, S_M, mfld(1, 1), 4'b0001);
    req1("R7 owner second", O_WR, 1, 1, 2, A_SUP, 8'h00, S_M, mfld(1, 2), 4'b0101);
    req1("R8 foreign write", O_WR, 6, 1, 3, A_INT, 8'h02, S_M, mfld(6, 1), 4'b1000);
    req1("R4 foreign read", O_RD, 0, 1, 1, A_INT, 8'h40, S_S, 8'h41, 4'b0000);
  endtask

  task automatic t_sole_sharer;
    req1("R3 read blk2", O_RD, 3, 2, 0, A_SUP, 8'h00, S_S, 8'h08, 4'b0000);
    req1("R5 sole sharer write", O_WR, 3, 2, 0, A_SUP, 8'h00, S_M, mfld(3, 1), 4'b0001);
    req1("R4 owner read", O_RD, 3, 2, 1, A_SUP, 8'h00, S_M, mfld(3, 1), 4'b0001);
  endtask

  task automatic t_full_count;
    req1("R6 cnt1", O_WR, 7, 3, 0, A_SUP, 8'h00, S_M, mfld(7, 1), 4'b0001);
    req1("R6 cnt2", O_WR, 7, 3, 1, A_SUP, 8'h00, S_M, mfld(7, 2), 4'b0011);
    req1("R6 cnt3", O_WR, 7, 3, 2, A_SUP, 8'h00, S_M, mfld(7, 3), 4'b0111);
    req1("R6 cnt4", O_WR, 7, 3, 3, A_SUP, 8'h00, S_M, mfld(7, 4), 4'b1111);
    req1("R10 reserved op", O_RS, 7, 3, 0, A_ERR, 8'h00, S_M, mfld(7, 4), 4'b1111);
  endtask

  task automatic t_isolation;
    req1("R11 blk2 untouched", O_RD, 3, 2, 2, A_SUP, 8'h00, S_M, mfld(3, 1), 4'b0001);
    req1("R11 blk4 untouched", O_WB, 3, 4, 0, A_ERR, 8'h00, S_I, 8'h00, 4'b0000);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    set_req(O_RD, 0, 5, 0);
    @(negedge clk);
    expect_rsp("R2 b2b first", A_SUP, 8'h00, S_S, 8'h01, 4'b0000);
    set_req(O_WR, 1, 5, 2);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R2 b2b second sees first", A_INV, 8'h01, S_M, mfld(1, 1), 4'b0100);
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: rsp_valid after stream=%b, expected 0", rsp_valid);
    end
  endtask

  bit done = 1'b0;

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_op     = 2'd0;
    req_core   = '0;
    req_blk    = '0;
    req_sector = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read_share();
    t_write_shared();
    t_owner_writes();
    t_writebacks();
    t_ownership_move();
    t_sole_sharer();
    t_full_count();
    t_isolation();
    t_back_to_back();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule